// File: doc/BRIEF.md
# DRAM Bank State Tracker

This block holds the timing state of every bank behind a DRAM controller. For each bank it keeps four things: the row that is open, the cycle at which the bank is next free, the earliest cycle at which that bank may be closed after its row was opened, and two counters for the open row (accesses and bytes). It also keeps a count of how many banks have a row open. It totals how long the device sits with every bank closed, and it remembers the time that idle stretch began.

The controller presents one event per cycle: an access to a bank and row, or an explicit close (precharge) of a bank, always with the current time. An access can be a row hit or a row miss. On a miss, any row already open is closed first and the new row is then opened. An access may also ask for an automatic close. Under the close-page policy every access opens the row, moves one burst and closes the row at once. Every close goes through one shared path, so the active-bank count and the idle accounting stay consistent. A query port reads back the state of any bank.

Top module: `dram_bank_tracker`

## Requirements
- R1: After reset every bank holds the no-row code (all ones), with free time, close-allowed time and both counters at zero. The active count, idle start, idle total and error flag are also zero.
- R2: An access (ev_op 0) to a bank with no open row opens the row at t_act = max(now, free). It sets close-allowed to t_act+T_RAS, free to t_act+T_RCD+T_CL, accesses to 1 and bytes to BURST. The active count rises by one.
- R3: Under the open-page policy, an access to the open row is a hit. It sets free to max(now, free)+T_CL and adds 1 to accesses and BURST to bytes, holding both once accesses is at its maximum. Close-allowed time and active count stay unchanged.
- R4: An access to a different row while a row is open first closes the bank at max(free, close-allowed, now)+T_RP. It then opens the new row as in R2, with that completion time as the free time. The active count ends unchanged.
- R5: An access with ev_auto_pre set ends with the bank closed. Its free time is max(free, close-allowed)+T_RP, taken from the values the access produced, and the bank no longer counts as active.
- R6: Under the close-page policy, an access to a closed bank opens it, counts one burst and closes it at max(free, close-allowed)+T_RP. The active count is unchanged.
- R7: An explicit close (ev_op 1) of an open bank sets its row to no-row and its free time to max(free, close-allowed, now)+T_RP. The active count falls by one.
- R8: Whenever a close brings the active count to zero, idle start becomes max(idle start, that close's completion time).
- R9: When a row is opened with zero banks active and t_act is later than idle start, t_act minus idle start is added to the idle total. The idle total changes at no other time.
- R10: An explicit close of a bank with no open row changes no bank state and no count, and it sets the error flag. The flag stays set until reset. The active count never goes outside 0 to the number of banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | An event is presented this cycle |
| ev_op | input | 1 | 0 = access, 1 = explicit close |
| ev_bank | input | IDX_W | Flat bank index (rank × banks + bank) |
| ev_row | input | ROW_W | Row addressed by an access |
| ev_now | input | TIME_W | Current time |
| ev_auto_pre | input | 1 | Close the bank after this access |
| close_page | input | 1 | Close-page policy selected |
| q_bank | input | IDX_W | Bank to read back |
| q_row | output | ROW_W | Open row of q_bank, all ones when none |
| q_free | output | TIME_W | Free time of q_bank |
| q_tras_done | output | TIME_W | Earliest close time of q_bank |
| q_row_acc | output | CNT_W | Accesses to the open row |
| q_bytes | output | BYTE_W | Bytes moved on the open row |
| active_banks | output | CNT_A_W | Number of banks with an open row |
| idle_start | output | TIME_W | Start of the current all-closed stretch |
| idle_total | output | TIME_W | Accumulated all-closed time |
| err | output | 1 | Sticky illegal-close flag |

## Verification
A bank entry written with the wrong value shows on the query port on the cycle after the event. Because the bench reads back every bank after every event, the error appears within one event. A drift in the active count is subtler: it shows at active_banks at once. It then also shows one or more events later as an idle total or idle start that has not moved, or that has moved when it should not. Mixed hit, miss, auto-close, close-page and explicit-close traffic therefore exposes a miscount within a few events of its cause.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
  typedef enum logic {
    OP_ACCESS    = 1'b0,
    OP_PRECHARGE = 1'b1
  } dbt_op_e;
endpackage

// File: rtl/dbt_bank_entry.sv
module dbt_bank_entry #(
  parameter int ROW_W  = 8,
  parameter int TIME_W = 16,
  parameter int CNT_W  = 6,
  parameter int BYTE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ROW_W-1:0]  d_row,
  input  logic [TIME_W-1:0] d_free,
  input  logic [TIME_W-1:0] d_tras,
  input  logic [CNT_W-1:0]  d_acc,
  input  logic [BYTE_W-1:0] d_bytes,
  output logic [ROW_W-1:0]  q_row,
  output logic [TIME_W-1:0] q_free,
  output logic [TIME_W-1:0] q_tras,
  output logic [CNT_W-1:0]  q_acc,
  output logic [BYTE_W-1:0] q_bytes
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_row   <= '1;
      q_free  <= '0;
      q_tras  <= '0;
      q_acc   <= '0;
      q_bytes <= '0;
    end else if (we) begin
      q_row   <= d_row;
      q_free  <= d_free;
      q_tras  <= d_tras;
      q_acc   <= d_acc;
      q_bytes <= d_bytes;
    end
  end
endmodule

// File: rtl/dbt_idle_acct.sv
module dbt_idle_acct #(
  parameter int NB      = 4,
  parameter int CNT_A_W = 3,
  parameter int TIME_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dec_a,
  input  logic [TIME_W-1:0]  t_a,
  input  logic               inc,
  input  logic [TIME_W-1:0]  t_inc,
  input  logic               dec_b,
  input  logic [TIME_W-1:0]  t_b,
  input  logic               bad_in,
  output logic [CNT_A_W-1:0] cnt,
  output logic [TIME_W-1:0]  start,
  output logic [TIME_W-1:0]  total,
  output logic               err
);
  localparam logic [CNT_A_W-1:0] FULL = CNT_A_W'(NB);

  function automatic logic [TIME_W-1:0] tmax2(input logic [TIME_W-1:0] a,
                                              input logic [TIME_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  logic [CNT_A_W-1:0] cnt_n;
  logic [TIME_W-1:0]  start_n, total_n;
  logic               fault;

  // Steps applied in event order: first close, open, trailing close
  always_comb begin
    cnt_n   = cnt;
    start_n = start;
    total_n = total;
    fault   = bad_in;
    if (dec_a) begin
      if (cnt_n == '0) fault = 1'b1;
      else begin
        cnt_n = cnt_n - 1'b1;
        if (cnt_n == '0) start_n = tmax2(start_n, t_a);
      end
    end
    if (inc) begin
      if (cnt_n == '0 && t_inc > start_n) total_n = total_n + (t_inc - start_n);
      if (cnt_n == FULL) fault = 1'b1;
      else cnt_n = cnt_n + 1'b1;
    end
    if (dec_b) begin
      if (cnt_n == '0) fault = 1'b1;
      else begin
        cnt_n = cnt_n - 1'b1;
        if (cnt_n == '0) start_n = tmax2(start_n, t_b);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      start <= '0;
      total <= '0;
      err   <= 1'b0;
    end else begin
      cnt   <= cnt_n;
      start <= start_n;
      total <= total_n;
      err   <= err | fault;
    end
  end
endmodule

// File: rtl/dram_bank_tracker.sv
module dram_bank_tracker
  import dbt_pkg::*;
#(
  parameter int RANKS  = 1,
  parameter int BANKS  = 4,
  parameter int ROW_W  = 8,
  parameter int TIME_W = 16,
  parameter int CNT_W  = 6,
  parameter int BURST  = 8,
  parameter int T_RAS  = 6,
  parameter int T_RP   = 3,
  parameter int T_RCD  = 2,
  parameter int T_CL   = 2,
  localparam int NB      = RANKS * BANKS,
  localparam int IDX_W   = (NB > 1) ? $clog2(NB) : 1,
  localparam int CNT_A_W = $clog2(NB + 1),
  localparam int BYTE_W  = CNT_W + $clog2(BURST)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_valid,
  input  logic               ev_op,
  input  logic [IDX_W-1:0]   ev_bank,
  input  logic [ROW_W-1:0]   ev_row,
  input  logic [TIME_W-1:0]  ev_now,
  input  logic               ev_auto_pre,
  input  logic               close_page,
  input  logic [IDX_W-1:0]   q_bank,
  output logic [ROW_W-1:0]   q_row,
  output logic [TIME_W-1:0]  q_free,
  output logic [TIME_W-1:0]  q_tras_done,
  output logic [CNT_W-1:0]   q_row_acc,
  output logic [BYTE_W-1:0]  q_bytes,
  output logic [CNT_A_W-1:0] active_banks,
  output logic [TIME_W-1:0]  idle_start,
  output logic [TIME_W-1:0]  idle_total,
  output logic               err
);
  localparam logic [ROW_W-1:0]  NO_ROW  = '1;
  localparam logic [TIME_W-1:0] RP_T    = TIME_W'(T_RP);
  localparam logic [TIME_W-1:0] RAS_T   = TIME_W'(T_RAS);
  localparam logic [TIME_W-1:0] CL_T    = TIME_W'(T_CL);
  localparam logic [TIME_W-1:0] RCDCL_T = TIME_W'(T_RCD + T_CL);
  localparam logic [CNT_W-1:0]  ACC_MAX = '1;
  localparam logic [BYTE_W-1:0] BURST_B = BYTE_W'(BURST);

  function automatic logic [TIME_W-1:0] tmax2(input logic [TIME_W-1:0] a,
                                              input logic [TIME_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [TIME_W-1:0] close_at(input logic [TIME_W-1:0] free_t,
                                                 input logic [TIME_W-1:0] tras_t,
                                                 input logic [TIME_W-1:0] now_t);
    return tmax2(tmax2(free_t, tras_t), now_t) + RP_T;
  endfunction

  // Per-bank storage
  logic [ROW_W-1:0]  row_a   [NB];
  logic [TIME_W-1:0] free_a  [NB];
  logic [TIME_W-1:0] tras_a  [NB];
  logic [CNT_W-1:0]  acc_a   [NB];
  logic [BYTE_W-1:0] bytes_a [NB];

  logic [ROW_W-1:0]  nx_row;
  logic [TIME_W-1:0] nx_free, nx_tras;
  logic [CNT_W-1:0]  nx_acc;
  logic [BYTE_W-1:0] nx_bytes;
  logic              entry_we;

  for (genvar g = 0; g < NB; g++) begin : g_bank
    dbt_bank_entry #(.ROW_W(ROW_W), .TIME_W(TIME_W), .CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_entry (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (entry_we && (ev_bank == IDX_W'(g))),
      .d_row  (nx_row),
      .d_free (nx_free),
      .d_tras (nx_tras),
      .d_acc  (nx_acc),
      .d_bytes(nx_bytes),
      .q_row  (row_a[g]),
      .q_free (free_a[g]),
      .q_tras (tras_a[g]),
      .q_acc  (acc_a[g]),
      .q_bytes(bytes_a[g])
    );
  end

  // Selected bank and event decode (named for the checker)
  logic [ROW_W-1:0]  cur_row;
  logic [TIME_W-1:0] cur_free, cur_tras;
  logic [CNT_W-1:0]  cur_acc;
  logic [BYTE_W-1:0] cur_bytes;
  logic cur_open, is_acc, is_pre, row_hit, miss_pre, act_fire, close_after;
  logic op_pre_ok, op_pre_bad;

  assign cur_row   = row_a[ev_bank];
  assign cur_free  = free_a[ev_bank];
  assign cur_tras  = tras_a[ev_bank];
  assign cur_acc   = acc_a[ev_bank];
  assign cur_bytes = bytes_a[ev_bank];

  assign cur_open    = (cur_row != NO_ROW);
  assign is_acc      = ev_valid && (ev_op == OP_ACCESS);
  assign is_pre      = ev_valid && (ev_op == OP_PRECHARGE);
  assign row_hit     = is_acc && cur_open && (cur_row == ev_row) && !close_page;
  assign miss_pre    = is_acc && cur_open && !row_hit;
  assign act_fire    = is_acc && !row_hit;
  assign close_after = is_acc && (close_page || ev_auto_pre);
  assign op_pre_ok   = is_pre && cur_open;
  assign op_pre_bad  = is_pre && !cur_open;

  // Timing arithmetic
  logic [TIME_W-1:0] t_miss_pre, free_after_pre, t_act, acc_free, acc_tras, t_close, t_op_pre;
  logic [CNT_W-1:0]  acc_cnt;
  logic [BYTE_W-1:0] acc_bytes;

  assign t_miss_pre     = close_at(cur_free, cur_tras, ev_now);
  assign free_after_pre = miss_pre ? t_miss_pre : cur_free;
  assign t_act          = tmax2(ev_now, free_after_pre);
  assign acc_free       = row_hit ? tmax2(ev_now, cur_free) + CL_T : t_act + RCDCL_T;
  assign acc_tras       = row_hit ? cur_tras : t_act + RAS_T;
  assign t_close        = tmax2(acc_free, acc_tras) + RP_T;
  assign t_op_pre       = close_at(cur_free, cur_tras, ev_now);

  always_comb begin
    if (!row_hit) begin
      acc_cnt   = CNT_W'(1);
      acc_bytes = BURST_B;
    end else if (cur_acc == ACC_MAX) begin
      acc_cnt   = cur_acc;
      acc_bytes = cur_bytes;
    end else begin
      acc_cnt   = cur_acc + 1'b1;
      acc_bytes = cur_bytes + BURST_B;
    end
  end

  always_comb begin
    entry_we = is_acc || op_pre_ok;
    nx_row   = cur_row;
    nx_free  = cur_free;
    nx_tras  = cur_tras;
    nx_acc   = cur_acc;
    nx_bytes = cur_bytes;
    if (is_acc) begin
      nx_row   = close_after ? NO_ROW : ev_row;
      nx_free  = close_after ? t_close : acc_free;
      nx_tras  = acc_tras;
      nx_acc   = acc_cnt;
      nx_bytes = acc_bytes;
    end else if (op_pre_ok) begin
      nx_row  = NO_ROW;
      nx_free = t_op_pre;
    end
  end

  // Shared close path into the active count and idle accounting
  dbt_idle_acct #(.NB(NB), .CNT_A_W(CNT_A_W), .TIME_W(TIME_W)) u_acct (
    .clk   (clk),
    .rst_n (rst_n),
    .dec_a (miss_pre || op_pre_ok),
    .t_a   (miss_pre ? t_miss_pre : t_op_pre),
    .inc   (act_fire),
    .t_inc (t_act),
    .dec_b (close_after),
    .t_b   (t_close),
    .bad_in(op_pre_bad),
    .cnt   (active_banks),
    .start (idle_start),
    .total (idle_total),
    .err   (err)
  );

  assign q_row       = row_a[q_bank];
  assign q_free      = free_a[q_bank];
  assign q_tras_done = tras_a[q_bank];
  assign q_row_acc   = acc_a[q_bank];
  assign q_bytes     = bytes_a[q_bank];
endmodule

// File: rtl/dbt_checker.sv
module dbt_checker #(
  parameter int NB      = 4,
  parameter int CNT_A_W = 3,
  parameter int TIME_W  = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ev_valid,
  input logic               ev_op,
  input logic               close_page,
  input logic               cur_open,
  input logic [CNT_A_W-1:0] active_banks,
  input logic [TIME_W-1:0]  idle_total,
  input logic               err
);
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active_banks <= CNT_A_W'(NB)); // R10
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(ev_valid && ev_op && !cur_open)); // R10
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R10
  AST_CLOSE_BALANCED: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_op && close_page && !cur_open) |=> active_banks == $past(active_banks)); // R6
  AST_PRE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_op && cur_open) |=> active_banks == $past(active_banks) - 1'b1); // R7
  AST_IDLE_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    idle_total >= $past(idle_total)); // R9
  AST_IDLE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_total != $past(idle_total)) |-> ($past(active_banks) <= CNT_A_W'(1))); // R9
endmodule

bind dram_bank_tracker dbt_checker #(.NB(NB), .CNT_A_W(CNT_A_W), .TIME_W(TIME_W)) u_dbt_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ev_valid    (ev_valid),
  .ev_op       (ev_op),
  .close_page  (close_page),
  .cur_open    (cur_open),
  .active_banks(active_banks),
  .idle_total  (idle_total),
  .err         (err)
);

// File: tb/test_dram_bank_tracker.sv
module test_dram_bank_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4, ROW_W = 8, TIME_W = 16, CNT_W = 6, BURST = 8;
  localparam int T_RAS = 6, T_RP = 3, T_RCD = 2, T_CL = 2;
  localparam int NO_ROW = 255, ACC_MAX = 63;
  localparam int N_EV = 600;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_valid = 1'b0, ev_op = 1'b0, ev_auto_pre = 1'b0, close_page = 1'b0;
  logic [1:0] ev_bank = '0, q_bank = '0;
  logic [ROW_W-1:0] ev_row = '0;
  logic [TIME_W-1:0] ev_now = '0;
  logic [ROW_W-1:0] q_row;
  logic [TIME_W-1:0] q_free, q_tras_done, idle_start, idle_total;
  logic [CNT_W-1:0] q_row_acc;
  logic [CNT_W+2:0] q_bytes;
  logic [2:0] active_banks;
  logic err;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_bank_tracker #(.RANKS(1), .BANKS(NB), .ROW_W(ROW_W), .TIME_W(TIME_W), .CNT_W(CNT_W),
    .BURST(BURST), .T_RAS(T_RAS), .T_RP(T_RP), .T_RCD(T_RCD), .T_CL(T_CL)) i_dram_bank_tracker (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_op(ev_op), .ev_bank(ev_bank),
    .ev_row(ev_row), .ev_now(ev_now), .ev_auto_pre(ev_auto_pre), .close_page(close_page),
    .q_bank(q_bank), .q_row(q_row), .q_free(q_free), .q_tras_done(q_tras_done),
    .q_row_acc(q_row_acc), .q_bytes(q_bytes), .active_banks(active_banks),
    .idle_start(idle_start), .idle_total(idle_total), .err(err));

  int n_chk = 0, n_bad = 0;
  int m_row [NB], m_free [NB], m_tras [NB], m_acc [NB], m_bytes [NB];
  int m_cnt, m_is, m_it, m_err;
  string tag;

  task automatic chk(input string t, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", t, what, act, exp);
    end
  endtask

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic m_close(input int b, input int t);
    m_row[b] = NO_ROW;
    m_free[b] = t;
    m_cnt = m_cnt - 1;
    if (m_cnt == 0) m_is = mx(m_is, t);
  endtask

  // Reference model of one event, written from the requirements
  task automatic model(input bit op, input int b, input int row, input int now,
                       input bit ap, input bit cp);
    int ta;
    if (op) begin
      if (m_row[b] == NO_ROW) begin m_err = 1; tag = "R10"; end
      else begin m_close(b, mx(mx(m_free[b], m_tras[b]), now) + T_RP); tag = "R7"; end
    end else begin
      if (m_row[b] != NO_ROW && m_row[b] == row && !cp) begin
        tag = "R3";
        m_free[b] = mx(now, m_free[b]) + T_CL;
        if (m_acc[b] < ACC_MAX) begin m_acc[b]++; m_bytes[b] += BURST; end
      end else begin
        tag = "R2";
        if (m_row[b] != NO_ROW) begin
          tag = "R4";
          m_close(b, mx(mx(m_free[b], m_tras[b]), now) + T_RP);
        end
        ta = mx(now, m_free[b]);
        if (m_cnt == 0 && ta > m_is) m_it += ta - m_is;
        m_cnt++;
        m_row[b] = row; m_tras[b] = ta + T_RAS; m_free[b] = ta + T_RCD + T_CL;
        m_acc[b] = 1; m_bytes[b] = BURST;
      end
      if (ap || cp) begin
        tag = cp ? "R6" : "R5";
        m_close(b, mx(m_free[b], m_tras[b]) + T_RP);
      end
    end
  endtask

  task automatic check_all(input string t);
    for (int b = 0; b < NB; b++) begin
      q_bank = 2'(b);
      #1;
      chk(t, "row", int'(q_row), m_row[b]);
      chk(t, "free", int'(q_free), m_free[b]);
      chk(t, "tras_done", int'(q_tras_done), m_tras[b]);
      chk(t, "row_acc", int'(q_row_acc), m_acc[b]);
      chk(t, "bytes", int'(q_bytes), m_bytes[b]);
    end
    chk("R10", "active_banks", int'(active_banks), m_cnt);
    chk("R8", "idle_start", int'(idle_start), m_is);
    chk("R9", "idle_total", int'(idle_total), m_it);
    chk("R10", "err", int'(err), m_err);
  endtask

  task automatic apply(input bit op, input int b, input int row, input int now,
                       input bit ap, input bit cp);
    @(negedge clk);
    ev_valid = 1'b1; ev_op = op; ev_bank = 2'(b); ev_row = ROW_W'(row);
    ev_now = TIME_W'(now); ev_auto_pre = ap; close_page = cp;
    @(negedge clk);
    ev_valid = 1'b0;
    model(op, b, row, now, ap, cp);
    check_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int now;
    logic [15:0] lf;
    for (int b = 0; b < NB; b++) begin
      m_row[b] = NO_ROW; m_free[b] = 0; m_tras[b] = 0; m_acc[b] = 0; m_bytes[b] = 0;
    end
    m_cnt = 0; m_is = 0; m_it = 0; m_err = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // Directed: open, hit, miss, auto-close, explicit close, idle gap
    apply(1'b0, 0, 5, 10, 1'b0, 1'b0); // R2 from idle: total grows by 10
    apply(1'b0, 0, 5, 11, 1'b0, 1'b0); // R3
    apply(1'b0, 0, 7, 12, 1'b0, 1'b0); // R4
    apply(1'b0, 1, 3, 13, 1'b1, 1'b0); // R5
    apply(1'b1, 0, 0, 30, 1'b0, 1'b0); // R7, count to zero: R8
    apply(1'b0, 2, 9, 60, 1'b0, 1'b1); // R6 with idle gap: R9
    apply(1'b0, 3, 4, 61, 1'b0, 1'b1); // R6
    apply(1'b1, 3, 0, 62, 1'b0, 1'b0); // R10 close of closed bank

    // Pseudo-random sweep over all banks, rows and policies
    now = 70;
    lf = 16'hACE1;
    for (int i = 0; i < N_EV; i++) begin
      bit op, ap, cp;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      op = (lf[2:0] == 3'd0);
      ap = lf[7] & lf[8];
      cp = (i < 200) ? 1'b0 : (i < 400) ? 1'b1 : lf[9];
      now = now + int'(lf[12:10]);
      apply(op, int'(lf[4:3]), int'(lf[6:5]), now, ap, cp);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule